// File: doc/BRIEF.md
# Threshold Data FIFO with Fill Reporting

This block buffers 32-bit data words between a processor-facing data register and the data engine that faces the card. It holds up to sixteen words. Its current occupancy is always visible as a 5-bit fill count, so the values 0 to 16 all fit. A single direction input selects who fills and who drains it. In read direction the engine pushes words that the card delivered and the processor takes them. In write direction the processor deposits words and the engine drains them toward the card.

A single shared data flag tells software when a burst of register accesses can go ahead. It has two separate 5-bit thresholds, one for each direction. In read direction the flag compares the words present against its threshold. In write direction it compares the free space against its threshold. Overflow and underflow attempts are refused and produce a one-cycle error pulse, which a status register can latch as a sticky FIFO error. A synchronous clear empties the buffer in one cycle.

Top module: `sdq_fifo`

## Requirements
- R1: After a synchronous reset, `fill` is 0, `fifo_err` is 0 and `rdata` is 0.
- R2: Words leave in the order they entered. A pop of a non-empty FIFO places the oldest word on `rdata` one cycle later. `rdata` keeps its value in every cycle without a pop.
- R3: `fill` rises by one for each accepted push and falls by one for each accepted pop. It ranges from 0 to 16 and takes effect one cycle after the request.
- R4: A push and a pop in the same cycle, with fill between 1 and 15, leave `fill` unchanged.
- R5: With `dir_rd`=1, `eng_push` and `eng_wdata` push and `cpu_rd` pops. With `dir_rd`=0, `cpu_wr` and `cpu_wdata` push and `eng_pop` pops. The strobes belonging to the other direction have no effect.
- R6: A push while `fill` is 16 is dropped. `fifo_err` is 1 for the following cycle, and the stored words are kept.
- R7: A pop while `fill` is 0 changes nothing in the store. `rdata` becomes 0 and `fifo_err` is 1 in the following cycle. A push in that same cycle is still accepted.
- R8: With `dir_rd`=1, `data_flag` is 1 exactly when `fill` >= `thr_rd`. The flag reflects the fill and the threshold of the preceding cycle's request, one cycle after the request.
- R9: With `dir_rd`=0, `data_flag` is 1 exactly when 16 - `fill` >= `thr_wr`. It has the same one-cycle timing as R8.
- R10: `clr` empties the FIFO on the next edge. It takes priority over any push or pop in that cycle, and it raises no error.
- R11: `eng_push_ok` is 1 exactly when `fill` < 16, and `eng_pop_ok` is 1 exactly when `fill` > 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the contents |
| dir_rd | input | 1 | 1: engine fills, processor drains; 0: the reverse |
| thr_rd | input | 5 | Fill threshold for the data flag in read direction |
| thr_wr | input | 5 | Free-space threshold for the data flag in write direction |
| cpu_wr | input | 1 | Processor write strobe on the data register |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe on the data register |
| eng_push | input | 1 | Engine push strobe |
| eng_wdata | input | 32 | Engine push data |
| eng_pop | input | 1 | Engine pop strobe |
| eng_push_ok | output | 1 | FIFO not full |
| eng_pop_ok | output | 1 | FIFO not empty |
| rdata | output | 32 | Registered pop data, shared by both readers |
| fill | output | 5 | Current number of stored words |
| data_flag | output | 1 | Threshold-based data flag |
| fifo_err | output | 1 | One-cycle overflow or underflow pulse |

## Verification
The properties assume that `rst` is held for at least one edge before it is checked. They also assume that the direction and threshold inputs are sampled at the same edge as the strobes, so the flag is always compared with the previous cycle's settings. Nothing is assumed about the strobes themselves: the stimulus deliberately pushes into a full FIFO, pops from an empty one, drives the wrong-direction strobes, and toggles direction, thresholds (including values above 16) and clear at random. The bench holds every input steady from one falling edge to the next, so each request is seen at exactly one rising edge.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  // Request presented to the pointer/count control after direction muxing.
  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } sdq_req_t;
endpackage

// File: rtl/sdq_ram.sv
module sdq_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  input  logic             zero,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Storage array without reset so it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; underflow loads zero, otherwise holds.
  always_ff @(posedge clk) begin
    if (rst)       rdata <= '0;
    else if (re)   rdata <= mem[raddr];
    else if (zero) rdata <= '0;
  end
endmodule

// File: rtl/sdq_ctrl.sv
module sdq_ctrl
  import sdq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  sdq_req_t      req,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic          rd_en,
  output logic [AW-1:0] raddr,
  output logic          rd_zero,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] count_nx,
  output logic          err_q
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic full, empty, push_acc, pop_acc;

  assign full     = (count_q == FULL);
  assign empty    = (count_q == '0);
  assign push_acc = req.push && !full;
  assign pop_acc  = req.pop && !empty;

  assign wr_en   = push_acc && !req.clr;
  assign rd_en   = pop_acc && !req.clr;
  assign rd_zero = req.pop && empty && !req.clr;

  always_comb begin
    if (rst || req.clr) begin
      count_nx = '0;
    end else begin
      unique case ({push_acc, pop_acc})
        2'b10:   count_nx = count_q + 1'b1;
        2'b01:   count_nx = count_q - 1'b1;
        default: count_nx = count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || req.clr) begin
      waddr <= '0;
      raddr <= '0;
      err_q <= 1'b0;
    end else begin
      if (wr_en) waddr <= (waddr == LAST) ? '0 : waddr + 1'b1;
      if (rd_en) raddr <= (raddr == LAST) ? '0 : raddr + 1'b1;
      err_q <= (req.push && full) || (req.pop && empty);
    end
    count_q <= count_nx;
  end
endmodule

// File: rtl/sdq_flag.sv
module sdq_flag #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          dir_rd,
  input  logic [CW-1:0] thr_rd,
  input  logic [CW-1:0] thr_wr,
  input  logic [CW-1:0] count_nx,
  output logic          flag_q
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] space_nx;
  assign space_nx = FULL - count_nx;

  // count_nx is forced to zero during reset, so the flag settles in reset too.
  always_ff @(posedge clk) begin
    if (dir_rd) flag_q <= (count_nx >= thr_rd);
    else        flag_q <= (space_nx >= thr_wr);
  end
endmodule

// File: rtl/sdq_fifo.sv
module sdq_fifo
  import sdq_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             dir_rd,
  input  logic [CW-1:0]    thr_rd,
  input  logic [CW-1:0]    thr_wr,
  input  logic             cpu_wr,
  input  logic [WIDTH-1:0] cpu_wdata,
  input  logic             cpu_rd,
  input  logic             eng_push,
  input  logic [WIDTH-1:0] eng_wdata,
  input  logic             eng_pop,
  output logic             eng_push_ok,
  output logic             eng_pop_ok,
  output logic [WIDTH-1:0] rdata,
  output logic [CW-1:0]    fill,
  output logic             data_flag,
  output logic             fifo_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  sdq_req_t         req;
  logic [WIDTH-1:0] push_data;
  logic             wr_en, rd_en, rd_zero;
  logic [AW-1:0]    waddr, raddr;
  logic [CW-1:0]    count_nx;

  // Direction picks the producer and the consumer.
  always_comb begin
    req.clr   = clr;
    req.push  = dir_rd ? eng_push : cpu_wr;
    req.pop   = dir_rd ? cpu_rd   : eng_pop;
    push_data = dir_rd ? eng_wdata : cpu_wdata;
  end

  sdq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .wr_en    (wr_en),
    .waddr    (waddr),
    .rd_en    (rd_en),
    .raddr    (raddr),
    .rd_zero  (rd_zero),
    .count_q  (fill),
    .count_nx (count_nx),
    .err_q    (fifo_err)
  );

  sdq_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) ram_i (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (push_data),
    .re    (rd_en),
    .raddr (raddr),
    .zero  (rd_zero),
    .rdata (rdata)
  );

  sdq_flag #(.DEPTH(DEPTH), .CW(CW)) flag_i (
    .clk      (clk),
    .dir_rd   (dir_rd),
    .thr_rd   (thr_rd),
    .thr_wr   (thr_wr),
    .count_nx (count_nx),
    .flag_q   (data_flag)
  );

  assign eng_push_ok = (fill != CW'(DEPTH));
  assign eng_pop_ok  = (fill != '0);
endmodule

// File: rtl/sdq_fifo_chk.sv
module sdq_fifo_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             dir_rd,
  input logic [CW-1:0]    thr_rd,
  input logic [CW-1:0]    thr_wr,
  input logic             cpu_wr,
  input logic             cpu_rd,
  input logic             eng_push,
  input logic             eng_pop,
  input logic             eng_pop_ok,
  input logic [WIDTH-1:0] rdata,
  input logic [CW-1:0]    fill,
  input logic             data_flag,
  input logic             fifo_err
);
  logic push_e, pop_e;
  assign push_e = dir_rd ? eng_push : cpu_wr;
  assign pop_e  = dir_rd ? cpu_rd : eng_pop;

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= DEPTH);

  a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (int'(fill) == int'($past(fill)) ||
              int'(fill) == int'($past(fill)) + 1 ||
              int'(fill) + 1 == int'($past(fill))));

  a_r4_pair_stable: assert property (@(posedge clk) disable iff (rst)
    (push_e && pop_e && !clr && fill != '0 && int'(fill) != DEPTH) |=> $stable(fill));

  a_r6_overflow_err: assert property (@(posedge clk) disable iff (rst)
    (push_e && !clr && int'(fill) == DEPTH) |=> fifo_err);

  a_r7_underflow_zero: assert property (@(posedge clk) disable iff (rst)
    (pop_e && !clr && fill == '0) |=> (fifo_err && rdata == '0));

  a_r8_flag_read: assert property (@(posedge clk) disable iff (rst)
    dir_rd |=> (data_flag == (int'(fill) >= int'($past(thr_rd)))));

  a_r9_flag_write: assert property (@(posedge clk) disable iff (rst)
    !dir_rd |=> (data_flag == (DEPTH - int'(fill) >= int'($past(thr_wr)))));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (fill == '0 && !fifo_err && !eng_pop_ok));
endmodule

bind sdq_fifo sdq_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW)) chk_i (.*);

// File: tb/sdq_fifo_tb_top.sv
module sdq_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 32;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rst, clr, dir_rd, cpu_wr, cpu_rd, eng_push, eng_pop;
  logic [CW-1:0] thr_rd, thr_wr;
  logic [WIDTH-1:0] cpu_wdata, eng_wdata;
  logic eng_push_ok, eng_pop_ok, data_flag, fifo_err;
  logic [WIDTH-1:0] rdata;
  logic [CW-1:0] fill;

  int nchk = 0;
  int nerr = 0;
  logic [WIDTH-1:0] mq[$];
  logic [WIDTH-1:0] m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .dir_rd(dir_rd),
    .thr_rd(thr_rd), .thr_wr(thr_wr),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
    .eng_push_ok(eng_push_ok), .eng_pop_ok(eng_pop_ok),
    .rdata(rdata), .fill(fill), .data_flag(data_flag), .fifo_err(fifo_err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit flag_exp(bit d, int n, int tr, int tw);
    return d ? (n >= tr) : (DEPTH - n >= tw);
  endfunction

  // Drive one request at a falling edge, model it, check at the next falling edge.
  task automatic cyc(bit c, bit d, bit cw, bit cr, bit ep, bit eo,
                     logic [31:0] wd, logic [CW-1:0] tr, logic [CW-1:0] tw, string req);
    bit push, pop, m_err;
    int n;
    string etag;
    clr = c; dir_rd = d; cpu_wr = cw; cpu_rd = cr; eng_push = ep; eng_pop = eo;
    cpu_wdata = wd; eng_wdata = ~wd; thr_rd = tr; thr_wr = tw;
    push = d ? ep : cw;
    pop  = d ? cr : eo;
    n = mq.size();
    etag = req;
    m_err = 1'b0;
    if (c) begin
      mq.delete();
    end else begin
      m_err = (push && n == DEPTH) || (pop && n == 0);
      if (push && n == DEPTH) etag = "R6";
      if (pop && n == 0) etag = "R7";
      if (pop && n > 0) m_rdata = mq.pop_front();
      else if (pop) m_rdata = '0;
      if (push && n < DEPTH) mq.push_back(d ? ~wd : wd);
    end
    @(negedge clk);
    n = mq.size();
    chk(req, "fill", 32'(fill), 32'(n));
    chk(etag, "fifo_err", 32'(fifo_err), 32'(m_err));
    chk((req == "R3") ? "R2" : req, "rdata", rdata, m_rdata);
    chk(d ? "R8" : "R9", "data_flag", 32'(data_flag), 32'(flag_exp(d, n, int'(tr), int'(tw))));
    chk("R11", "eng_pop_ok", 32'(eng_pop_ok), 32'(n != 0));
    chk("R11", "eng_push_ok", 32'(eng_push_ok), 32'(n != DEPTH));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; clr = 1'b0; dir_rd = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0;
    eng_push = 1'b0; eng_pop = 1'b0; cpu_wdata = '0; eng_wdata = '0;
    thr_rd = 5'd4; thr_wr = 5'd4;
    m_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "fill", 32'(fill), 0);
    chk("R1", "fifo_err", 32'(fifo_err), 0);
    chk("R1", "rdata", rdata, 0);
    chk("R8", "data_flag", 32'(data_flag), 0);

    // R3/R6: fill to 16 from the engine, then one more push overflows
    for (int i = 0; i < 17; i++) cyc(0, 1, 0, 0, 1, 0, 32'h1000 + i, 4, 4, "R3");
    // R2/R7: processor drains in order, then one read underflows
    for (int i = 0; i < 17; i++) cyc(0, 1, 0, 1, 0, 0, 0, 4, 4, "R2");

    // R5: wrong-side strobes in read direction
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, 1, 32'hA0 + i, 4, 4, "R5");
    // R5: wrong-side strobes in write direction
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 0, 32'hB0 + i, 4, 4, "R5");

    // R9: processor fills in write direction with a high free-space threshold
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 0, 0, 32'hC0 + i, 4, 12, "R3");
    // R4: simultaneous push and pop
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0, 1, 32'hD0 + i, 4, 10, "R4");
    // R10: clear wins over push and pop
    cyc(1, 0, 1, 0, 0, 1, 32'hE0, 4, 4, "R10");
    cyc(0, 0, 0, 0, 1, 0, 0, 4, 4, "R10");
    // R7: push and pop together while empty: pop errors, push accepted
    cyc(0, 0, 1, 0, 0, 1, 32'hF0, 4, 4, "R7");
    cyc(0, 0, 0, 0, 1, 0, 0, 4, 0, "R2");

    // Random phase
    begin
      bit d = 1'b1;
      logic [CW-1:0] tr = 5'd4, tw = 5'd4;
      for (int i = 0; i < 4000; i++) begin
        int bias;
        bias = ((i / 200) % 2 == 0) ? 60 : 40;
        if ($urandom_range(0, 49) == 0) d = ~d;
        if ($urandom_range(0, 99) == 0) tr = 5'($urandom_range(0, 20));
        if ($urandom_range(0, 99) == 0) tw = 5'($urandom_range(0, 20));
        cyc($urandom_range(0, 199) == 0, d,
            $urandom_range(0, 99) < bias, $urandom_range(0, 99) < 100 - bias,
            $urandom_range(0, 99) < bias, $urandom_range(0, 99) < 100 - bias,
            $urandom, tr, tw, "R3");
      end
    end
    finish_run();
  end
endmodule